// File: doc/BRIEF.md
# Stored-Program Byte Processor Core

This block is a small processor that runs programs held in the same 256-byte memory as the data they work on. It has sixteen one-byte general registers and no accumulator. Each instruction is two bytes long. The high nibble of the first byte selects the operation, and the other three nibbles are operand fields that name registers, give a memory address or immediate byte, or give a rotate count. The control unit repeats a fixed loop. It fetches the high instruction byte, then fetches the low byte and advances the program counter by two, then executes. The loop stops when a halt instruction is executed.

The surrounding logic holds the core in reset while it writes a program and its data into memory through a backdoor port. It then releases reset, and the core begins fetching at the address presented on `start_addr`. When `halted` goes high, the results are read back through the same backdoor port. The program counter is also visible on an output.

Top module: `spc_core`

## Requirements
- R1: While reset is held, `halted` is low. After reset is released, the PC is loaded from `start_addr` and all sixteen registers read as zero.
- R2: A fetch reads the byte at PC as the high instruction byte and the byte at PC+1 as the low byte, then advances PC by 2. For example, 156C placed at A0 loads memory byte 6C into register 5 and leaves PC at A2.
- R3: Opcode 1 RXY copies memory byte XY into register R. Opcode 2 RXY loads the constant XY into register R. Opcode 3 RXY writes register R to memory byte XY.
- R4: Opcode 4 with operand digits 0RS copies register R into register S. The first operand digit has no effect.
- R5: Opcode 5 RST writes S+T modulo 256 (two's complement) into register R.
- R6: Opcodes 7, 8 and 9 RST write the bitwise OR, AND and XOR of registers S and T into register R.
- R7: Opcode A R0X rotates register R right by X modulo 8 bit positions. A count of 0 or 8 leaves the value unchanged, and the middle digit has no effect.
- R8: Opcode B RXY sets PC to XY when register R equals register 0, and otherwise falls through to PC+2. With R=0 the jump is always taken.
- R9: Opcode C halts the core, whatever its operand digits. `halted` goes high, PC stays frozen at the halt address plus 2, and no later instruction runs until the next reset.
- R10: Opcodes 0, 6, D, E and F change no register and no memory byte, and execution continues with the next instruction.
- R11: PC wraps modulo 256. An instruction at FE is followed by the one at 00.
- R12: A write on the backdoor port stores `bd_wdata` at `bd_addr` on the clock edge. `bd_rdata` always shows the memory byte at `bd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_addr | input | 8 | Address of the first instruction, taken after reset |
| halted | output | 1 | High once a halt instruction has executed |
| pc_o | output | 8 | Current program counter |
| bd_we | input | 1 | Backdoor memory write enable |
| bd_addr | input | 8 | Backdoor memory address |
| bd_wdata | input | 8 | Backdoor write data |
| bd_rdata | output | 8 | Memory byte at `bd_addr` |

## Verification
The bench sweeps 256 operand pairs through add and the three logic operations. It includes pairs that overflow past 255 and the 7F+01 sign boundary; a design with the wrong carry width or a swapped logic opcode returns wrong stored bytes. The bench runs rotates over every count from 0 to 15. A design that treats counts of 8 or more as a full shift, or that reads the middle digit, returns wrong bytes. The remaining checks cover these cases:
- Both outcomes of the equal-to-register-0 jump are run. Reversing the comparison stores the wrong marker and leaves PC at the wrong place.
- Halts with non-zero operand digits are run. A design that keeps running after halt or lets PC drift overwrites a guarded byte.
- A program that wraps past FE is run. Broken wrap logic never reaches the store.
- Every no-op opcode is run next to a guarded memory byte. A no-op that writes changes the guarded byte.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int NREG    = 16;
  localparam int RAW     = $clog2(NREG);
  localparam int IW      = 2 * DW;
  localparam int ROTW    = $clog2(DW);

  localparam logic [3:0] OP_LDM  = 4'h1;
  localparam logic [3:0] OP_LDI  = 4'h2;
  localparam logic [3:0] OP_STM  = 4'h3;
  localparam logic [3:0] OP_MOV  = 4'h4;
  localparam logic [3:0] OP_ADD  = 4'h5;
  localparam logic [3:0] OP_OR   = 4'h7;
  localparam logic [3:0] OP_AND  = 4'h8;
  localparam logic [3:0] OP_XOR  = 4'h9;
  localparam logic [3:0] OP_ROR  = 4'hA;
  localparam logic [3:0] OP_JEQ  = 4'hB;
  localparam logic [3:0] OP_HALT = 4'hC;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_EXEC,
    ST_HALT
  } state_t;
endpackage

// File: rtl/spc_mem.sv
module spc_mem #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata_a = store_q[raddr_a];
  assign rdata_b = store_q[raddr_b];
endmodule

// File: rtl/spc_regfile.sv
module spc_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  input  logic [RAW-1:0] raddr_c,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b,
  output logic [DW-1:0]  rdata_c,
  output logic [DW-1:0]  rdata_zero
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (waddr == RAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (en) begin
        regs_q[g] <= wdata;
      end
    end
  end

  assign rdata_a    = regs_q[raddr_a];
  assign rdata_b    = regs_q[raddr_b];
  assign rdata_c    = regs_q[raddr_c];
  assign rdata_zero = regs_q[0];

  // R10: without a write strobe the register contents hold
  a_r10_idle_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q));

  // R3: a write lands in the addressed register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/spc_alu.sv
module spc_alu #(
  parameter int DW = 8,
  localparam int ROTW = $clog2(DW)
) (
  input  logic [3:0]      op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [ROTW-1:0] rot,
  output logic [DW-1:0]   y
);
  import spc_pkg::*;

  logic [2*DW-1:0] rot_wide;

  always_comb begin
    rot_wide = {a, a} >> rot;
    case (op)
      OP_ADD:  y = a + b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_ROR:  y = rot_wide[DW-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/spc_core.sv
module spc_core
  import spc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_addr,
  output logic          halted,
  output logic [AW-1:0] pc_o,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [DW-1:0] bd_wdata,
  output logic [DW-1:0] bd_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  state_t        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;
  logic [IW-1:0] ir_q, ir_d;
  logic          ir_en;

  logic [3:0]     op;
  logic [RAW-1:0] fld_r, fld_s, fld_t;
  logic [AW-1:0]  imm;

  assign op    = ir_q[IW-1 -: 4];
  assign fld_r = ir_q[11:8];
  assign fld_s = ir_q[7:4];
  assign fld_t = ir_q[3:0];
  assign imm   = ir_q[AW-1:0];

  // memory wiring
  logic [AW-1:0] core_raddr;
  logic [DW-1:0] core_rdata;
  logic          core_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  // register file wiring
  logic           rf_we;
  logic [RAW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata;
  logic [RAW-1:0] rf_raddr_a;
  logic [DW-1:0]  rd_a, rd_b, rd_c, rd_zero;
  logic [DW-1:0]  alu_a, alu_y;

  logic in_exec;
  logic jump_hit;

  assign in_exec  = (state_q == ST_EXEC);
  assign jump_hit = in_exec && (op == OP_JEQ) && (rd_a == rd_zero);

  // next-state logic
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    ir_d    = ir_q;
    ir_en   = 1'b0;
    case (state_q)
      ST_BOOT: begin
        pc_d    = start_addr;
        pc_en   = 1'b1;
        state_d = ST_FETCH_HI;
      end
      ST_FETCH_HI: begin
        ir_d    = {core_rdata, ir_q[DW-1:0]};
        ir_en   = 1'b1;
        state_d = ST_FETCH_LO;
      end
      ST_FETCH_LO: begin
        ir_d    = {ir_q[IW-1:DW], core_rdata};
        ir_en   = 1'b1;
        pc_d    = pc_q + AW'(2);
        pc_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (jump_hit) begin
          pc_d  = imm;
          pc_en = 1'b1;
        end
        state_d = (op == OP_HALT) ? ST_HALT : ST_FETCH_HI;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_BOOT;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  // operand and write-back decode
  always_comb begin
    case (state_q)
      ST_FETCH_HI: core_raddr = pc_q;
      ST_FETCH_LO: core_raddr = pc_q + AW'(1);
      default:     core_raddr = imm;
    endcase

    rf_raddr_a = (op == OP_MOV) ? fld_s : fld_r;
    alu_a      = (op == OP_ROR) ? rd_a : rd_b;

    rf_we    = 1'b0;
    rf_waddr = fld_r;
    rf_wdata = alu_y;
    core_we  = 1'b0;
    if (in_exec) begin
      case (op)
        OP_LDM: begin rf_we = 1'b1; rf_wdata = core_rdata; end
        OP_LDI: begin rf_we = 1'b1; rf_wdata = imm; end
        OP_STM: core_we = 1'b1;
        OP_MOV: begin rf_we = 1'b1; rf_waddr = fld_t; rf_wdata = rd_a; end
        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
        default: ;
      endcase
    end
  end

  assign mem_we    = bd_we | core_we;
  assign mem_waddr = bd_we ? bd_addr  : imm;
  assign mem_wdata = bd_we ? bd_wdata : rd_a;

  spc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (core_raddr),
    .rdata_a (core_rdata),
    .raddr_b (bd_addr),
    .rdata_b (bd_rdata)
  );

  spc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (rf_we),
    .waddr      (rf_waddr),
    .wdata      (rf_wdata),
    .raddr_a    (rf_raddr_a),
    .raddr_b    (fld_s),
    .raddr_c    (fld_t),
    .rdata_a    (rd_a),
    .rdata_b    (rd_b),
    .rdata_c    (rd_c),
    .rdata_zero (rd_zero)
  );

  spc_alu #(.DW(DW)) u_alu (
    .op  (op),
    .a   (alu_a),
    .b   (rd_c),
    .rot (fld_t[ROTW-1:0]),
    .y   (alu_y)
  );

  assign halted = (state_q == ST_HALT);
  assign pc_o   = pc_q;

  // R1: the PC is taken from the start address on leaving boot
  a_r1_boot_pc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q == ST_BOOT |=> pc_q == $past(start_addr));

  // R2: the low-byte fetch steps the PC by two
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q == ST_FETCH_LO |=> pc_q == $past(pc_q) + AW'(2));

  // R8: a matching compare redirects the PC
  a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    jump_hit |=> pc_q == $past(imm));

  // R9: once halted, state and PC are frozen
  a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> halted && $stable(pc_q));

  // R7: rotate by a multiple of eight returns the source unchanged
  a_r7_rot_identity: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_exec && op == OP_ROR && fld_t[ROTW-1:0] == '0) |-> rf_wdata == rd_a);

  // R10: no-op codes neither write a register nor memory
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_exec && (op == 4'h0 || op == 4'h6 || op >= 4'hD)) |-> !rf_we && !core_we);
endmodule

// File: tb/spc_core_bench.sv
module spc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] start_addr = 8'h00;
  logic       halted;
  logic [7:0] pc_o;
  logic       bd_we = 1'b0;
  logic [7:0] bd_addr = 8'h00;
  logic [7:0] bd_wdata = 8'h00;
  logic [7:0] bd_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spc_core u_spc_core (
    .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .halted(halted),
    .pc_o(pc_o), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
    .bd_rdata(bd_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_wdata = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic put16(input logic [7:0] a, input logic [15:0] w);
    put8(a, w[15:8]);
    put8(a + 8'd1, w[7:0]);
  endtask

  task automatic get8(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bd_addr = a;
    #1 d = bd_rdata;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] sa, input string req);
    int n;
    start_addr = sa;
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    nchk++;
    if (!halted) begin
      nfail++;
      $display("FAIL %s run did not halt actual=0 expected=1", req);
    end
  endtask

  function automatic logic [7:0] ror8(input logic [7:0] v, input int x);
    int k = x % 8;
    int w = int'(v);
    return 8'(((w >> k) | (w << (8 - k))) & 255);
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] pc_keep;

    // R1: halted low in reset
    hold_reset();
    chk("R1 halted in reset", {7'd0, halted}, 8'h00);

    // R12: backdoor write and read
    put8(8'h33, 8'hC6);
    get8(8'h33, d);
    chk("R12 backdoor readback", d, 8'hC6);

    // R2 / R3: load from memory at A0, fetch order and PC
    put8(8'h6C, 8'h9E);
    put16(8'hA0, 16'h156C);
    put16(8'hA2, 16'h35F0);
    put16(8'hA4, 16'hC000);
    run(8'hA0, "R2");
    get8(8'hF0, d);
    chk("R2 R3 load 156C", d, 8'h9E);
    chk("R2 pc after halt at A4", pc_o, 8'hA6);

    // R1: registers clear after reset (set R9 first, then read it after reset)
    hold_reset();
    put16(8'h00, 16'h2933);
    put16(8'h02, 16'hC000);
    run(8'h00, "R1");
    hold_reset();
    put8(8'hF1, 8'hEE);
    put16(8'h10, 16'h39F1);
    put16(8'h12, 16'hC000);
    run(8'h10, "R1");
    get8(8'hF1, d);
    chk("R1 register cleared by reset", d, 8'h00);
    chk("R1 pc from start_addr", pc_o, 8'h14);

    // R4: move, first digit ignored
    hold_reset();
    put16(8'h00, 16'h235A);
    put16(8'h02, 16'h4F37);
    put16(8'h04, 16'h37F0);
    put16(8'h06, 16'h33F1);
    put16(8'h08, 16'hC000);
    run(8'h00, "R4");
    get8(8'hF0, d);
    chk("R4 move dest", d, 8'h5A);
    get8(8'hF1, d);
    chk("R4 move source kept", d, 8'h5A);

    // R5 / R6: sweep of operand pairs
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a = 8'(i * 37 + 5);
        logic [7:0] b = 8'(j * 53 + 200);
        hold_reset();
        put16(8'h00, {8'h21, a});
        put16(8'h02, {8'h22, b});
        put16(8'h04, 16'h5312);
        put16(8'h06, 16'h7412);
        put16(8'h08, 16'h8512);
        put16(8'h0A, 16'h9612);
        put16(8'h0C, 16'h33E0);
        put16(8'h0E, 16'h34E1);
        put16(8'h10, 16'h35E2);
        put16(8'h12, 16'h36E3);
        put16(8'h14, 16'hC000);
        run(8'h00, "R5");
        get8(8'hE0, d); chk("R5 add sweep", d, 8'((int'(a) + int'(b)) % 256));
        get8(8'hE1, d); chk("R6 or sweep",  d, a | b);
        get8(8'hE2, d); chk("R6 and sweep", d, a & b);
        get8(8'hE3, d); chk("R6 xor sweep", d, a ^ b);
      end
    end

    // R5: sign boundary and carry out
    hold_reset();
    put16(8'h00, 16'h217F);
    put16(8'h02, 16'h2201);
    put16(8'h04, 16'h23FF);
    put16(8'h06, 16'h5412);
    put16(8'h08, 16'h5532);
    put16(8'h0A, 16'h34E0);
    put16(8'h0C, 16'h35E1);
    put16(8'h0E, 16'hC000);
    run(8'h00, "R5");
    get8(8'hE0, d); chk("R5 7F+01", d, 8'h80);
    get8(8'hE1, d); chk("R5 FF+01 wraps", d, 8'h00);

    // R7: rotate sweep, middle digit set to 7 (ignored)
    for (int vi = 0; vi < 4; vi++) begin
      for (int x = 0; x < 16; x++) begin
        logic [7:0] v;
        case (vi)
          0: v = 8'h01;
          1: v = 8'h80;
          2: v = 8'hA5;
          default: v = 8'h3C;
        endcase
        hold_reset();
        put16(8'h00, {8'h21, v});
        put16(8'h02, {8'hA1, 4'h7, 4'(x)});
        put16(8'h04, 16'h31F0);
        put16(8'h06, 16'hC000);
        run(8'h00, "R7");
        get8(8'hF0, d);
        chk("R7 rotate sweep", d, ror8(v, x));
      end
    end

    // R8: jump taken / not taken
    for (int t = 0; t < 3; t++) begin
      hold_reset();
      put16(8'h00, 16'h2044);
      put16(8'h02, (t == 1) ? 16'h2145 : 16'h2144);
      put16(8'h04, (t == 2) ? 16'hB010 : 16'hB110);
      put16(8'h06, 16'h22AA);
      put16(8'h08, 16'h32F2);
      put16(8'h0A, 16'hC000);
      put16(8'h10, 16'h22BB);
      put16(8'h12, 16'h32F2);
      put16(8'h14, 16'hC000);
      run(8'h00, "R8");
      get8(8'hF2, d);
      chk("R8 jump path marker", d, (t == 1) ? 8'hAA : 8'hBB);
      chk("R8 pc after jump path", pc_o, (t == 1) ? 8'h0C : 8'h16);
    end

    // R10: no-op opcodes
    hold_reset();
    put8(8'hF4, 8'h5C);
    put16(8'h00, 16'h2111);
    put16(8'h02, 16'h01F4);
    put16(8'h04, 16'h61F4);
    put16(8'h06, 16'hD1F4);
    put16(8'h08, 16'hE1F4);
    put16(8'h0A, 16'hF1F4);
    put16(8'h0C, 16'h31F3);
    put16(8'h0E, 16'hC000);
    run(8'h00, "R10");
    get8(8'hF3, d); chk("R10 register untouched by no-ops", d, 8'h11);
    get8(8'hF4, d); chk("R10 memory untouched by no-ops", d, 8'h5C);
    chk("R10 execution continued", pc_o, 8'h10);

    // R9: halt with digits, freeze, guarded store not run
    hold_reset();
    put8(8'hF5, 8'h77);
    put16(8'h20, 16'hC123);
    put16(8'h22, 16'h31F5);
    run(8'h20, "R9");
    chk("R9 pc at halt", pc_o, 8'h22);
    pc_keep = pc_o;
    repeat (20) @(negedge clk);
    chk("R9 pc frozen", pc_o, pc_keep);
    chk("R9 still halted", {7'd0, halted}, 8'h01);
    get8(8'hF5, d); chk("R9 no instruction after halt", d, 8'h77);

    // R11: wrap from FE to 00
    hold_reset();
    put16(8'hFE, 16'h216D);
    put16(8'h00, 16'h31F6);
    put16(8'h02, 16'hC000);
    run(8'hFE, "R11");
    get8(8'hF6, d); chk("R11 wrapped store", d, 8'h6D);
    chk("R11 pc after wrap", pc_o, 8'h04);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule